// File: doc/BRIEF.md
# Parallel Block Boxcar Decimator

This block takes one wide word per clock from a fast converter front end. The word is made of four synchronized lanes of 32 bits. Each lane carries four 8-bit samples, so every clock brings 16 samples. Because of how the converter spreads samples over its lanes, the lanes are not in time order. The block first restores true time order. It then adds each run of four consecutive samples. The result is four decimated samples per clock: a 4:1 rate reduction with a moving-sum (sinc-shaped) low-pass response. Keeping every fourth sample and dropping the rest would throw away the benefit of oversampling, so the block adds all four.

Two build-time parameters select the lane interleave and the input code format. One interleave scatters consecutive samples across the lanes. The other keeps each lane as a contiguous run of time. The code format is either two's complement or offset binary. The output is always two's complement and wide enough that no sum can overflow. The pipeline has two registered stages. A valid flag travels with each block, and no state carries over from one block to the next.

Top module: `boxdec_top`

## Requirements
- R1: Lane j of `din` occupies bits [32j+31:32j], and sample k of a lane occupies bits [8k+7:8k] within that lane (j, k in 0..3).
- R2: With INTERLEAVE=1, sample k of lane j has time index 4k+j.
- R3: With INTERLEAVE=0, sample k of lane j has time index 4j+k.
- R4: Output g (0..3) is the sum of the samples with time indices 4g to 4g+3. It is placed at `dout`[10g+9:10g], so output 0 holds the earliest samples.
- R5: With OFFSET_BIN=0, input codes are two's-complement values and outputs are 10-bit two's complement. The extremes are -512 when every code is 0x80 and +508 when every code is 0x7F.
- R6: With OFFSET_BIN=1, each input code represents its value minus 128, and outputs are 10-bit two's complement. All 0x00 gives -512, all 0xFF gives +508, and all 0x80 gives 0.
- R7: `valid_out` is high exactly two clocks after each cycle in which `valid_in` is high, and low two clocks after each cycle in which it is low.
- R8: A cycle with `valid_in` low has no effect on `dout`, which holds the result of the last valid block.
- R9: A synchronous `rst` clears `valid_out` and `dout` to zero at the next clock edge.
- R10: Blocks on consecutive clocks give independent results, each depending only on its own 16 samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | `din` holds a block this cycle |
| din | input | 128 | Four lanes of four 8-bit samples |
| valid_out | output | 1 | `dout` holds a new result |
| dout | output | 40 | Four 10-bit sums, earliest at the bottom |

## Verification
The bench builds two instances side by side and drives them with the same stimulus. One uses the scattered interleave with two's-complement codes. The other uses the contiguous interleave with offset-binary codes. Between them, one pattern exercises both lane mappings and both code formats, including the extreme sums at either end of the 10-bit range. Streams of back-to-back blocks, idle gaps carrying junk data, and a reset in mid-stream are applied to both instances together.

// File: rtl/boxdec_pkg.sv
package boxdec_pkg;

  localparam int GRP = 4;

  // Bit offset in the input word of the sample with time index t.
  function automatic int src_bit(input int t, input int lanes, input int spl,
                                 input int sw, input bit interleave);
    int lane;
    int samp;
    if (interleave) begin
      lane = t % lanes;
      samp = t / lanes;
    end else begin
      lane = t / spl;
      samp = t % spl;
    end
    return (lane * spl + samp) * sw;
  endfunction

endpackage

// File: rtl/boxdec_reorder.sv
module boxdec_reorder #(
  parameter int  LANES      = 4,
  parameter int  SPL        = 4,
  parameter int  SW         = 8,
  parameter bit  INTERLEAVE = 1'b1,
  localparam int NS         = LANES * SPL
) (
  input  logic [NS*SW-1:0] din,
  output logic [NS*SW-1:0] dtime
);

  for (genvar t = 0; t < NS; t++) begin : g_slot
    localparam int SRC = boxdec_pkg::src_bit(t, LANES, SPL, SW, INTERLEAVE);
    assign dtime[t*SW +: SW] = din[SRC +: SW];
  end

endmodule

// File: rtl/boxdec_pair_stage.sv
module boxdec_pair_stage #(
  parameter int  NS         = 16,
  parameter int  SW         = 8,
  parameter bit  OFFSET_BIN = 1'b0,
  localparam int NP         = NS / 2,
  localparam int PW         = SW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vin,
  input  logic [NS*SW-1:0] tsamp,
  output logic             vout,
  output logic [NP*PW-1:0] pairs
);

  function automatic logic [SW-1:0] to_twos(input logic [SW-1:0] code);
    logic [SW-1:0] r;
    r = code;
    if (OFFSET_BIN) r[SW-1] = ~code[SW-1];
    return r;
  endfunction

  function automatic logic [PW-1:0] add_pair(input logic [SW-1:0] a,
                                             input logic [SW-1:0] b);
    logic [SW-1:0] sa;
    logic [SW-1:0] sb;
    sa = to_twos(a);
    sb = to_twos(b);
    return {sa[SW-1], sa} + {sb[SW-1], sb};
  endfunction

  logic [NP*PW-1:0] pair_d;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    assign pair_d[p*PW +: PW] = add_pair(tsamp[(2*p)*SW +: SW],
                                         tsamp[(2*p+1)*SW +: SW]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vout  <= 1'b0;
      pairs <= '0;
    end else begin
      vout <= vin;
      if (vin) pairs <= pair_d;
    end
  end

  AST_S1_VALID_HI: assert property (@(posedge clk) disable iff (rst)
    vin |=> vout) else $error("stage1 valid lost"); // R7
  AST_S1_VALID_LO: assert property (@(posedge clk) disable iff (rst)
    !vin |=> !vout) else $error("stage1 spurious valid"); // R7
  AST_S1_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vin |=> $stable(pairs)) else $error("stage1 changed while idle"); // R8

endmodule

// File: rtl/boxdec_sum_stage.sv
module boxdec_sum_stage #(
  parameter int  NG = 4,
  parameter int  PW = 9,
  localparam int OW = PW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vin,
  input  logic [2*NG*PW-1:0] pairs,
  output logic               vout,
  output logic [NG*OW-1:0]   sums
);

  function automatic logic [OW-1:0] add_wide(input logic [PW-1:0] a,
                                             input logic [PW-1:0] b);
    return {a[PW-1], a} + {b[PW-1], b};
  endfunction

  logic [NG*OW-1:0] sum_d;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign sum_d[g*OW +: OW] = add_wide(pairs[(2*g)*PW +: PW],
                                        pairs[(2*g+1)*PW +: PW]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vout <= 1'b0;
      sums <= '0;
    end else begin
      vout <= vin;
      if (vin) sums <= sum_d;
    end
  end

  AST_S2_VALID_HI: assert property (@(posedge clk) disable iff (rst)
    vin |=> vout) else $error("stage2 valid lost"); // R7
  AST_S2_VALID_LO: assert property (@(posedge clk) disable iff (rst)
    !vin |=> !vout) else $error("stage2 spurious valid"); // R7
  AST_S2_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vin |=> $stable(sums)) else $error("stage2 changed while idle"); // R8

endmodule

// File: rtl/boxdec_top.sv
module boxdec_top #(
  parameter int  LANES      = 4,
  parameter int  SPL        = 4,
  parameter int  SW         = 8,
  parameter bit  INTERLEAVE = 1'b1,
  parameter bit  OFFSET_BIN = 1'b0,
  localparam int NS         = LANES * SPL,
  localparam int NG         = NS / boxdec_pkg::GRP,
  localparam int PW         = SW + 1,
  localparam int OW         = SW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic [NS*SW-1:0] din,
  output logic             valid_out,
  output logic [NG*OW-1:0] dout
);

  logic [NS*SW-1:0] time_ordered;
  logic [NS/2*PW-1:0] pair_q;
  logic             valid_s1;

  boxdec_reorder #(
    .LANES(LANES), .SPL(SPL), .SW(SW), .INTERLEAVE(INTERLEAVE)
  ) u_reorder (
    .din  (din),
    .dtime(time_ordered)
  );

  boxdec_pair_stage #(
    .NS(NS), .SW(SW), .OFFSET_BIN(OFFSET_BIN)
  ) u_pair (
    .clk  (clk),
    .rst  (rst),
    .vin  (valid_in),
    .tsamp(time_ordered),
    .vout (valid_s1),
    .pairs(pair_q)
  );

  boxdec_sum_stage #(
    .NG(NG), .PW(PW)
  ) u_sum (
    .clk  (clk),
    .rst  (rst),
    .vin  (valid_s1),
    .pairs(pair_q),
    .vout (valid_out),
    .sums (dout)
  );

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RST_CLEAR: assert (!valid_out && dout == '0)
        else $error("outputs not cleared by reset"); // R9
    end
  end

endmodule

// File: tb/sim_boxdec_top.sv
`timescale 1ns/1ps
module sim_boxdec_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         vin = 1'b0;
  logic [127:0] din = '0;
  logic         v0, v1;
  logic [39:0]  d0, d1;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  boxdec_top #(.INTERLEAVE(1'b1), .OFFSET_BIN(1'b0)) u0 (
    .clk(clk), .rst(rst), .valid_in(vin), .din(din), .valid_out(v0), .dout(d0));
  boxdec_top #(.INTERLEAVE(1'b0), .OFFSET_BIN(1'b1)) u1 (
    .clk(clk), .rst(rst), .valid_in(vin), .din(din), .valid_out(v1), .dout(d1));

  // Expected sums built from the requirements: time t -> lane/sample (R2, R3),
  // code -> value (R5, R6), group sums packed earliest first (R4).
  function automatic logic [39:0] model(input logic [127:0] blk, input bit il, input bit ob);
    logic [39:0] r;
    r = '0;
    for (int g = 0; g < 4; g++) begin
      int acc;
      acc = 0;
      for (int m = 0; m < 4; m++) begin
        int t, lane, smp;
        logic [7:0] c;
        t    = 4 * g + m;
        lane = il ? (t % 4) : (t / 4);
        smp  = il ? (t / 4) : (t % 4);
        c    = blk[lane*32 + smp*8 +: 8];
        acc  = acc + (ob ? (int'(c) - 128) : int'($signed(c)));
      end
      r[g*10 +: 10] = 10'(acc);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(v0 == 1'b0 && v1 == 1'b0, "R9 valid after reset", {38'd0, v1, v0}, 40'd0);
    chk(d0 == '0, "R9 dout u0 after reset", d0, 40'd0);
    chk(d1 == '0, "R9 dout u1 after reset", d1, 40'd0);
  endtask

  // One isolated block: latency, data of both instances, hold while idle.
  task automatic t_one(input logic [127:0] blk, input string tag);
    logic [39:0] e0, e1;
    e0 = model(blk, 1'b1, 1'b0);
    e1 = model(blk, 1'b0, 1'b1);
    @(negedge clk); vin = 1'b1; din = blk;
    @(negedge clk);
    chk(v0 == 1'b0 && v1 == 1'b0, {"R7 not early ", tag}, {38'd0, v1, v0}, 40'd0);
    vin = 1'b0; din = ~blk;
    @(negedge clk);
    chk(v0 == 1'b1 && v1 == 1'b1, {"R7 two-cycle valid ", tag}, {38'd0, v1, v0}, 40'd3);
    chk(d0 == e0, {"R2 R4 R5 u0 ", tag}, d0, e0);
    chk(d1 == e1, {"R3 R4 R6 u1 ", tag}, d1, e1);
    din = {4{32'hDEAD_BEEF}};
    @(negedge clk);
    chk(v0 == 1'b0 && v1 == 1'b0, {"R7 single pulse ", tag}, {38'd0, v1, v0}, 40'd0);
    @(negedge clk);
    chk(d0 == e0 && d1 == e1, {"R8 hold while idle ", tag}, d0 ^ d1, e0 ^ e1);
  endtask

  task automatic t_extreme(input logic [7:0] code, input logic [39:0] e0,
                           input logic [39:0] e1, input string tag);
    @(negedge clk); vin = 1'b1; din = {16{code}};
    @(negedge clk); vin = 1'b0;
    @(negedge clk);
    chk(d0 == e0, {"R5 extreme ", tag}, d0, e0);
    chk(d1 == e1, {"R6 extreme ", tag}, d1, e1);
  endtask

  task automatic t_stream();
    logic [127:0] blk [6];
    for (int i = 0; i < 6; i++)
      for (int w = 0; w < 4; w++)
        blk[i][w*32 +: 32] = (i + 1) * 32'h9E37_79B9 ^ (w * 32'h0101_0101) ^ (i << 13);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk(v0 && v1, "R10 stream valid", {38'd0, v1, v0}, 40'd3);
        chk(d0 == model(blk[i-2], 1'b1, 1'b0), "R10 stream u0", d0, model(blk[i-2], 1'b1, 1'b0));
        chk(d1 == model(blk[i-2], 1'b0, 1'b1), "R10 stream u1", d1, model(blk[i-2], 1'b0, 1'b1));
      end
      vin = (i < 6);
      din = (i < 6) ? blk[i] : '0;
    end
    @(negedge clk);
    vin = 1'b0;
    @(negedge clk);
    chk(!v0 && !v1, "R7 stream drains", {38'd0, v1, v0}, 40'd0);
  endtask

  task automatic t_mid_reset();
    @(negedge clk); vin = 1'b1; din = {4{32'h1234_5678}};
    @(negedge clk); vin = 1'b1; din = {4{32'h7F7F_7F7F}};
    @(negedge clk); vin = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!v0 && !v1, "R9 mid-run valid", {38'd0, v1, v0}, 40'd0);
    chk(d0 == '0 && d1 == '0, "R9 mid-run dout", d0 | d1, 40'd0);
    @(negedge clk);
    chk(!v0 && !v1, "R9 flushed block", {38'd0, v1, v0}, 40'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    begin
      logic [127:0] ramp;
      for (int b = 0; b < 16; b++) ramp[b*8 +: 8] = 8'(3 * b + 1);
      t_one(ramp, "ramp");
    end
    t_one({32'd0, 32'h0403_0201, 32'd0, 32'd0}, "R1 lane2 only");
    t_one({4{32'hF010_80C3}}, "mixed signs");
    t_extreme(8'h80, {4{10'h200}}, {4{10'h000}}, "0x80");
    t_extreme(8'h7F, {4{10'h1FC}}, {4{10'h3FC}}, "0x7F");
    t_extreme(8'hFF, {4{10'h3FC}}, {4{10'h1FC}}, "0xFF");
    t_extreme(8'h00, {4{10'h000}}, {4{10'h200}}, "0x00");
    t_stream();
    t_mid_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule